// File: doc/BRIEF.md
# I2S Transmit Channel with Underflow Recovery

This block is a master-mode I2S transmitter. Stereo samples arrive through a simple write port. A write with the left selector stores the left word. A write with the right selector pushes the left/right pair into an eight-entry FIFO. A serializer takes one pair per frame from the FIFO and drives bit clock, word select and serial data. The left word goes first and each word is sent MSB first. Clock, polarity, alignment and interrupt options come from two configuration buses. A status word and two interrupt lines report the FIFO level and underflow.

When the serializer finds the FIFO empty at a frame boundary, it keeps sending either zeroes or the previous pair. When recovery is enabled, an empty fetch also starts a state machine with four states: `REC_IDLE`, `REC_HALT`, `REC_FILL` and `REC_RESUME`. Its transitions are:
- trigger (`REC_IDLE`→`REC_HALT`): taken on an underflow when recovery is on. It bumps a saturating event counter.
- stop (`REC_HALT`→`REC_FILL`): the channel is held off, the serializer returns to bit 0 of the frame, and the FIFO pointers are cleared.
- filled (`REC_FILL`→`REC_RESUME`): `REC_FILL` pushes one zero pair per cycle. This transition is taken once the full flag is seen.
- release (`REC_RESUME`→`REC_IDLE`): the channel is enabled again.

While the state is anything other than `REC_IDLE`, the busy flag is set and host writes are dropped. The restarted stream therefore begins on a frame boundary and has several frames of silence in hand.

Top module: `i2s_tx_recover`

## Requirements
- R1: After reset the status word reads only the empty flag (bit 13). Both interrupt lines, the event counter and serial data are low.
- R2: A right-select write pushes {last left word, data}. The level appears in status bits [3:0] and full in bit 12. A push while the FIFO holds 8 pairs is dropped.
- R3: Each frame is 32 bit-clock periods, with the left slot first and each slot MSB first. Data is valid at rising bit-clock edges. Word select is low for the left slot and is inverted by clock config bit 0. With config bit 2 clear, word select changes one bit before the slot; with it set, it changes with the slot.
- R4: Transmit config bit 3 places the 12-bit sample in the low end of the 16-bit slot. When it is clear, the sample is placed in the high end. The remaining bits are zero.
- R5: Clock config bit 1 inverts the bit clock. With config bit 4 clear, the bit clock rests at its idle level while the channel is stopped. With bit 4 set, it toggles anyway. With config bit 3 clear, no frames start and no data is drawn.
- R6: With transmit config bit 2 set, the empty interrupt is raised at level ≤ 4 when config bit 0 is 0, and at level 0 when config bit 0 is 1.
- R7: Status bit 15 is set by a fetch from an empty FIFO and cleared by any accepted push. The underflow interrupt is that flag gated by transmit config bit 1.
- R8: With recovery off, an empty fetch sends a zero pair when transmit config bit 4 is 0, and repeats the previous pair when it is 1.
- R9: With transmit config bit 5 set, an empty fetch sets busy (status bit 14) on the next cycle for 11 cycles. The FIFO is then full of zero pairs, and the 4-bit event counter has risen by one, saturating at 15.
- R10: Host writes made while busy is set leave the FIFO contents unchanged.
- R11: After recovery, or after the channel is re-enabled, output restarts at bit 0 of a new frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ch_en | input | 1 | Channel enable |
| cfg_clk | input | 5 | Clock config: ws invert, bclk invert, no delay, master, free bclk |
| cfg_tx | input | 6 | Transmit config: empty level, underflow irq enable, empty irq enable, right justify, repeat on underflow, recovery enable |
| wr_en | input | 1 | Sample write strobe |
| wr_right | input | 1 | 0 stores the left word; 1 pushes the pair |
| wr_data | input | 12 | Sample word |
| status | output | 16 | Level, full, empty, busy, underflow |
| irq_empty | output | 1 | FIFO-level interrupt |
| irq_underflow | output | 1 | Underflow interrupt |
| rec_count | output | 4 | Saturating recovery counter |
| i2s_bclk | output | 1 | Bit clock |
| i2s_ws | output | 1 | Word select |
| i2s_sd | output | 1 | Serial data |

## Verification
Status and interrupt outputs are combinational on registered state, so they are due in the cycle after the write or fetch edge. The bench model updates at that same edge, and the outputs are compared at the following falling edge on every clock.

Frame fetches fall on the first enabled cycle and then every 128 cycles. Busy rises in the cycle after an empty fetch and stays high for 11 cycles. The first bit-clock rise follows the start cycle by three cycles.

The bench rebuilds each frame from the pins at rising bit-clock edges, indexed from the modelled frame start. It compares the whole frame against the pair the model fetched at that boundary.

// File: rtl/i2s_tx_pkg.sv
`timescale 1ns/1ps
package i2s_tx_pkg;
    typedef enum logic [1:0] {REC_IDLE, REC_HALT, REC_FILL, REC_RESUME} rec_state_e;
    // clock configuration bit positions
    localparam int CK_WS_INV    = 0;
    localparam int CK_BCLK_INV  = 1;
    localparam int CK_NO_DELAY  = 2;
    localparam int CK_MASTER    = 3;
    localparam int CK_FREE_BCLK = 4;
    // transmit configuration bit positions
    localparam int TX_LVL_EMPTY = 0;
    localparam int TX_UF_IE     = 1;
    localparam int TX_EMP_IE    = 2;
    localparam int TX_RJUST     = 3;
    localparam int TX_UF_REPEAT = 4;
    localparam int TX_REC_EN    = 5;
    // status bit positions
    localparam int ST_FULL  = 12;
    localparam int ST_EMPTY = 13;
    localparam int ST_BUSY  = 14;
    localparam int ST_UF    = 15;
endpackage

// File: rtl/i2s_tx_fifo.sv
`timescale 1ns/1ps
module i2s_tx_fifo #(
    parameter int W     = 24,
    parameter int DEPTH = 8
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          flush,
    input  logic                          push_req,
    input  logic [W-1:0]                  din,
    input  logic                          pop_req,
    output logic [W-1:0]                  head,
    output logic [$clog2(DEPTH+1)-1:0]    level,
    output logic                          full,
    output logic                          empty
);
    localparam int AW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH+1);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wp, rp;
    logic [CW-1:0] cnt;
    logic          push_ok, pop_ok;

    assign full    = (cnt == CW'(DEPTH));
    assign empty   = (cnt == '0);
    assign push_ok = push_req && !full;
    assign pop_ok  = pop_req && !empty;
    assign head    = mem[rp];
    assign level   = cnt;

    always_ff @(posedge clk) begin
        if (push_ok && !flush) mem[wp] <= din;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else if (flush) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else begin
            if (push_ok) wp <= (wp == AW'(DEPTH-1)) ? '0 : wp + 1'b1;
            if (pop_ok)  rp <= (rp == AW'(DEPTH-1)) ? '0 : rp + 1'b1;
            unique case ({push_ok, pop_ok})
                2'b10:   cnt <= cnt + 1'b1;
                2'b01:   cnt <= cnt - 1'b1;
                default: cnt <= cnt;
            endcase
        end
    end

    a_r2_level_bound: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CW'(DEPTH));
    a_r9_flush_clears: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> empty);
    a_r2_full_drop: assert property (@(posedge clk) disable iff (!rst_n)
        (full && push_req && !pop_req && !flush) |=> full);
endmodule

// File: rtl/i2s_tx_ser.sv
`timescale 1ns/1ps
module i2s_tx_ser #(
    parameter int SAMPLE_W = 12,
    parameter int SLOT_W   = 16,
    parameter int DIV      = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  run,
    input  logic                  free_bclk,
    input  logic                  bclk_inv,
    input  logic                  ws_inv,
    input  logic                  no_delay,
    input  logic                  rjust,
    input  logic                  uf_repeat,
    input  logic                  fifo_empty,
    input  logic [2*SAMPLE_W-1:0] head,
    output logic                  load,
    output logic                  uf_evt,
    output logic                  bclk,
    output logic                  ws,
    output logic                  sd
);
    localparam int FRAME = 2*SLOT_W;
    localparam int SW    = $clog2(SLOT_W);
    localparam int PW    = SW + 1;
    localparam int DW    = $clog2(DIV);

    logic                  started, phase, tick, fall, last;
    logic [DW-1:0]         cnt;
    logic [PW-1:0]         pos, wpos;
    logic [2*SAMPLE_W-1:0] cur;
    logic [SAMPLE_W-1:0]   word;
    logic [SLOT_W-1:0]     slot_vec;
    logic [SW-1:0]         slot_b;

    assign tick   = (cnt == DW'(DIV-1));
    assign fall   = tick && phase;
    assign last   = (pos == PW'(FRAME-1));
    assign load   = run && (!started || (fall && last));
    assign uf_evt = load && fifo_empty;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            started <= 1'b0;
            cnt     <= '0;
            phase   <= 1'b0;
            pos     <= '0;
        end else if (!run) begin
            started <= 1'b0;
            pos     <= '0;
            if (free_bclk) begin
                cnt <= tick ? '0 : cnt + 1'b1;
                if (tick) phase <= !phase;
            end else begin
                cnt   <= '0;
                phase <= 1'b0;
            end
        end else if (!started) begin
            started <= 1'b1;
            cnt     <= '0;
            phase   <= 1'b0;
            pos     <= '0;
        end else begin
            cnt <= tick ? '0 : cnt + 1'b1;
            if (tick) phase <= !phase;
            if (fall) pos <= last ? '0 : pos + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                cur <= '0;
        else if (load && !fifo_empty) cur <= head;
        else if (load && !uf_repeat)  cur <= '0;
    end

    always_comb begin
        slot_b   = pos[SW-1:0];
        word     = pos[PW-1] ? cur[SAMPLE_W-1:0] : cur[2*SAMPLE_W-1:SAMPLE_W];
        slot_vec = rjust ? SLOT_W'(word) : (SLOT_W'(word) << (SLOT_W - SAMPLE_W));
        wpos     = pos + (no_delay ? PW'(0) : PW'(1));
        sd       = started && slot_vec[~slot_b];
        ws       = wpos[PW-1] ^ ws_inv;
        bclk     = ((free_bclk || started) && phase) ^ bclk_inv;
    end

    a_r11_start_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(started) |-> (pos == '0 && !phase));
    a_r3_fetch_on_boundary: assert property (@(posedge clk) disable iff (!rst_n)
        (load && started) |-> last);
    a_r5_gated_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (!free_bclk && !started) |-> (bclk == bclk_inv && !sd));
endmodule

// File: rtl/i2s_tx_recov.sv
`timescale 1ns/1ps
module i2s_tx_recov
    import i2s_tx_pkg::*;
#(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rec_en,
    input  logic             uf_evt,
    input  logic             fifo_full,
    output logic             busy,
    output logic             flush,
    output logic             fill_push,
    output logic [CNT_W-1:0] rec_count
);
    rec_state_e st, st_nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= REC_IDLE;
        else        st <= st_nx;
    end

    always_comb begin
        st_nx     = st;
        busy      = 1'b1;
        flush     = 1'b0;
        fill_push = 1'b0;
        unique case (st)
            REC_IDLE: begin
                busy = 1'b0;
                if (rec_en && uf_evt) st_nx = REC_HALT;
            end
            REC_HALT: begin
                flush = 1'b1;
                st_nx = REC_FILL;
            end
            REC_FILL: begin
                if (fifo_full) st_nx = REC_RESUME;
                else           fill_push = 1'b1;
            end
            REC_RESUME: st_nx = REC_IDLE;
            default:    st_nx = REC_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rec_count <= '0;
        else if (st == REC_IDLE && st_nx == REC_HALT && rec_count != '1)
            rec_count <= rec_count + 1'b1;
    end

    a_r9_halt_to_fill: assert property (@(posedge clk) disable iff (!rst_n)
        (st == REC_HALT) |=> (st == REC_FILL));
    a_r9_trigger_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (st == REC_IDLE && rec_en && uf_evt) |=> busy);
    a_r9_count_step: assert property (@(posedge clk) disable iff (!rst_n)
        (rec_count == $past(rec_count)) || (rec_count == $past(rec_count) + 1'b1));
    a_r9_resume_once: assert property (@(posedge clk) disable iff (!rst_n)
        (st == REC_RESUME) |=> !busy);
endmodule

// File: rtl/i2s_tx_recover.sv
`timescale 1ns/1ps
module i2s_tx_recover
    import i2s_tx_pkg::*;
#(
    parameter int SAMPLE_W = 12,
    parameter int SLOT_W   = 16,
    parameter int DIV      = 2,
    parameter int DEPTH    = 8,
    parameter int CNT_W    = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                ch_en,
    input  logic [4:0]          cfg_clk,
    input  logic [5:0]          cfg_tx,
    input  logic                wr_en,
    input  logic                wr_right,
    input  logic [SAMPLE_W-1:0] wr_data,
    output logic [15:0]         status,
    output logic                irq_empty,
    output logic                irq_underflow,
    output logic [CNT_W-1:0]    rec_count,
    output logic                i2s_bclk,
    output logic                i2s_ws,
    output logic                i2s_sd
);
    localparam int PAIR_W = 2*SAMPLE_W;
    localparam int LW     = $clog2(DEPTH+1);

    logic                busy, flush, fill_push, load, uf_evt, full, empty, run;
    logic                host_push, push_req, uf_flag;
    logic [SAMPLE_W-1:0] pend_l;
    logic [PAIR_W-1:0]   head, din;
    logic [LW-1:0]       level;

    assign run       = ch_en && cfg_clk[CK_MASTER] && !busy;
    assign host_push = wr_en && wr_right && !busy;
    assign push_req  = host_push || fill_push;
    assign din       = fill_push ? '0 : {pend_l, wr_data};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                          pend_l <= '0;
        else if (wr_en && !wr_right && !busy) pend_l <= wr_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                uf_flag <= 1'b0;
        else if (push_req && !full) uf_flag <= 1'b0;
        else if (uf_evt)            uf_flag <= 1'b1;
    end

    i2s_tx_fifo #(.W(PAIR_W), .DEPTH(DEPTH)) u_fifo (
        .clk(clk), .rst_n(rst_n), .flush(flush), .push_req(push_req), .din(din),
        .pop_req(load), .head(head), .level(level), .full(full), .empty(empty)
    );

    i2s_tx_ser #(.SAMPLE_W(SAMPLE_W), .SLOT_W(SLOT_W), .DIV(DIV)) u_ser (
        .clk(clk), .rst_n(rst_n), .run(run),
        .free_bclk(cfg_clk[CK_FREE_BCLK]), .bclk_inv(cfg_clk[CK_BCLK_INV]),
        .ws_inv(cfg_clk[CK_WS_INV]), .no_delay(cfg_clk[CK_NO_DELAY]),
        .rjust(cfg_tx[TX_RJUST]), .uf_repeat(cfg_tx[TX_UF_REPEAT]),
        .fifo_empty(empty), .head(head), .load(load), .uf_evt(uf_evt),
        .bclk(i2s_bclk), .ws(i2s_ws), .sd(i2s_sd)
    );

    i2s_tx_recov #(.CNT_W(CNT_W)) u_recov (
        .clk(clk), .rst_n(rst_n), .rec_en(cfg_tx[TX_REC_EN]), .uf_evt(uf_evt),
        .fifo_full(full), .busy(busy), .flush(flush), .fill_push(fill_push),
        .rec_count(rec_count)
    );

    always_comb begin
        status           = '0;
        status[LW-1:0]   = level;
        status[ST_FULL]  = full;
        status[ST_EMPTY] = empty;
        status[ST_BUSY]  = busy;
        status[ST_UF]    = uf_flag;
        irq_empty        = cfg_tx[TX_EMP_IE] &&
                           (cfg_tx[TX_LVL_EMPTY] ? empty : (level <= LW'(DEPTH/2)));
        irq_underflow    = cfg_tx[TX_UF_IE] && uf_flag;
    end

    a_r10_busy_holds_level: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !flush && !fill_push) |=> (level == $past(level)));
    a_r7_uf_set: assert property (@(posedge clk) disable iff (!rst_n)
        (uf_evt && !push_req) |=> uf_flag);
endmodule

// File: tb/i2s_tx_recover_tb.sv
`timescale 1ns/1ps
module i2s_tx_recover_tb;
    localparam int DEPTH = 8;
    localparam int P     = 128;
    localparam int FRAME = 32;

    logic        clk = 0, rst_n = 0, ch_en = 0, wr_en = 0, wr_right = 0;
    logic [4:0]  cfg_clk = 5'b01000;
    logic [5:0]  cfg_tx  = 6'b0;
    logic [11:0] wr_data = '0;
    logic [15:0] status;
    logic        irq_empty, irq_underflow, i2s_bclk, i2s_ws, i2s_sd;
    logic [3:0]  rec_count;

    i2s_tx_recover u_dut (
        .clk(clk), .rst_n(rst_n), .ch_en(ch_en), .cfg_clk(cfg_clk), .cfg_tx(cfg_tx),
        .wr_en(wr_en), .wr_right(wr_right), .wr_data(wr_data), .status(status),
        .irq_empty(irq_empty), .irq_underflow(irq_underflow), .rec_count(rec_count),
        .i2s_bclk(i2s_bclk), .i2s_ws(i2s_ws), .i2s_sd(i2s_sd)
    );

    always #4 clk = ~clk;

    int    checks = 0, errs = 0, cyc = 0;
    string cur_req = "R3";

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    // behavioural model
    logic [23:0] mq[$];
    logic [11:0] m_pend = '0;
    logic [23:0] m_cur = '0, exp_pair = '0;
    int          m_state = 0, m_ph = 0, m_cnt = 0;
    bit          m_started = 0, m_uf = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            mq.delete(); m_pend = '0; m_cur = '0; m_state = 0; m_ph = 0;
            m_cnt = 0; m_started = 0; m_uf = 0;
        end else begin
            bit busy, run, full, empty, load, ufe, hpush, fpush;
            busy  = (m_state != 0);
            run   = ch_en && cfg_clk[3] && !busy;
            full  = (mq.size() == DEPTH);
            empty = (mq.size() == 0);
            load  = run && (!m_started || m_ph == P);
            ufe   = load && empty;
            hpush = wr_en && wr_right && !busy && !full;
            fpush = (m_state == 2) && !full;
            if (!run) m_started = 0;
            else if (!m_started) begin m_started = 1; m_ph = 1; end
            else m_ph = (m_ph == P) ? 1 : m_ph + 1;
            if (load) begin
                if (!empty) m_cur = mq.pop_front();
                else if (!cfg_tx[4]) m_cur = '0;
                exp_pair = m_cur;
            end
            if (hpush) mq.push_back({m_pend, wr_data});
            if (fpush) mq.push_back(24'h0);
            if (wr_en && !wr_right && !busy) m_pend = wr_data;
            if (hpush || fpush) m_uf = 0;
            else if (ufe) m_uf = 1;
            case (m_state)
                0: if (ufe && cfg_tx[5]) begin m_state = 1; if (m_cnt < 15) m_cnt++; end
                1: begin mq.delete(); m_state = 2; end
                2: if (full) m_state = 3;
                default: m_state = 0;
            endcase
        end
    end

    function automatic logic [31:0] exp_bits(input logic [23:0] pr, input bit rj);
        logic [15:0] l, r;
        l = rj ? {4'b0, pr[23:12]} : {pr[23:12], 4'b0};
        r = rj ? {4'b0, pr[11:0]}  : {pr[11:0], 4'b0};
        return {l, r};
    endfunction

    // per-cycle comparison and serial capture
    int          bi = 0;
    bit          pb = 0, ws_bad = 0;
    logic [31:0] fr = '0;
    always @(negedge clk) begin
        if (rst_n) begin
            int  sz;
            bit  b, wexp;
            sz = mq.size();
            chk(status[3:0] == 4'(sz) && status[12] == (sz == DEPTH) && status[13] == (sz == 0),
                "R2 level/full/empty", status, sz);
            chk(status[14] == (m_state != 0) && rec_count == 4'(m_cnt), "R9 busy/count",
                {status[14], rec_count}, {(m_state != 0), 4'(m_cnt)});
            chk(status[15] == m_uf && irq_underflow == (cfg_tx[1] && m_uf), "R7 underflow flag/irq",
                {status[15], irq_underflow}, {m_uf, cfg_tx[1] && m_uf});
            chk(irq_empty == (cfg_tx[2] && (cfg_tx[0] ? sz == 0 : sz <= DEPTH/2)), "R6 empty irq",
                irq_empty, cfg_tx[2] && (cfg_tx[0] ? sz == 0 : sz <= DEPTH/2));
            b = i2s_bclk ^ cfg_clk[1];
            if (!m_started) begin
                bi = 0; ws_bad = 0;
            end else if (b && !pb) begin
                fr = {fr[30:0], i2s_sd};
                wexp = ((((bi + (cfg_clk[2] ? 0 : 1)) % FRAME) >= 16) ? 1'b1 : 1'b0) ^ cfg_clk[0];
                if (i2s_ws != wexp) ws_bad = 1;
                bi++;
                if (bi == FRAME) begin
                    chk(fr == exp_bits(exp_pair, cfg_tx[3]), cur_req, fr, exp_bits(exp_pair, cfg_tx[3]));
                    chk(!ws_bad, "R3 word select", ws_bad, 0);
                    bi = 0; ws_bad = 0;
                end
            end
            pb = b;
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            errs++; checks++;
            $display("FAIL watchdog act=%0d exp<150000", cyc);
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end

    task automatic tick_in();
        @(posedge clk); #1;
    endtask

    task automatic wr(input logic [11:0] l, input logic [11:0] r);
        tick_in(); wr_en = 1; wr_right = 0; wr_data = l;
        tick_in(); wr_right = 1; wr_data = r;
        tick_in(); wr_en = 0; wr_right = 0;
    endtask

    task automatic wait_busy(input bit lvl);
        int n = 0;
        do begin @(negedge clk); n++; end while (status[14] != lvl && n < 5000);
    endtask

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk);
        chk(status == 16'h2000 && !irq_empty && !irq_underflow && rec_count == 0 && !i2s_sd,
            "R1 reset state", {status, rec_count}, 20'h20000);
        tick_in(); rst_n = 1;

        // R2 writes, overflow drop; R3 standard framing; R8 zero fill
        cfg_clk = 5'b01000; cfg_tx = 6'b000110;
        for (int i = 0; i < 9; i++) wr(12'h100 + 12'(i) * 12'h111, 12'hA05 ^ 12'(i * 37));
        @(negedge clk);
        chk(status[12] && status[3:0] == 8, "R2 full at 8", status, 16'h1008);
        tick_in(); ch_en = 1; cur_req = "R3";
        repeat (3 * P) @(posedge clk);
        tick_in(); cfg_tx[0] = 1;
        repeat (6 * P) @(posedge clk);
        cur_req = "R8 zero fill";
        repeat (3 * P) @(posedge clk);
        @(negedge clk);
        chk(irq_underflow, "R7 underflow irq", irq_underflow, 1);

        // R8 repeat mode
        tick_in(); ch_en = 0; cfg_tx = 6'b010010;
        wr(12'h123, 12'h456); wr(12'hFED, 12'h0C3);
        tick_in(); ch_en = 1; cur_req = "R8 repeat";
        repeat (5 * P) @(posedge clk);
        wr(12'h777, 12'h888);
        cur_req = "R7/R8";
        repeat (3 * P) @(posedge clk);

        // R4 right-justify with inverted polarities, no delay
        tick_in(); ch_en = 0; cfg_clk = 5'b01111; cfg_tx = 6'b001000;
        for (int i = 0; i < 4; i++) wr(12'h8F1 + 12'(i), 12'h3C0 - 12'(i));
        tick_in(); ch_en = 1; cur_req = "R4 right justify";
        repeat (5 * P) @(posedge clk);

        // R5 bit clock gating and master bit
        begin
            int toggles = 0;
            bit first, bad = 0;
            tick_in(); ch_en = 0; cfg_clk = 5'b11010; cfg_tx = 6'b0;
            @(negedge clk); first = i2s_bclk;
            for (int i = 0; i < 40; i++) begin @(negedge clk); if (i2s_bclk != first) toggles++; first = i2s_bclk; end
            chk(toggles > 5, "R5 free bclk toggles", toggles, 10);
            tick_in(); cfg_clk = 5'b00010;
            @(negedge clk);
            for (int i = 0; i < 40; i++) begin @(negedge clk); if (i2s_bclk != 1'b1) bad = 1; end
            chk(!bad, "R5 gated idle inverted", bad, 0);
            wr(12'h111, 12'h222);
            tick_in(); ch_en = 1;
            for (int i = 0; i < 300; i++) begin @(negedge clk); if (i2s_sd || i2s_bclk != 1'b1) bad = 1; end
            chk(!bad && status[3:0] == 1, "R5 master off draws nothing", status[3:0], 1);
            tick_in(); ch_en = 0; cfg_clk = 5'b01000;
        end

        // R9/R10/R11 recovery
        tick_in(); cfg_tx = 6'b100010;
        wr(12'hABC, 12'hDEF);
        tick_in(); ch_en = 1; cur_req = "R11 realign";
        wait_busy(1);
        wr(12'h5A5, 12'hA5A);
        wait_busy(0);
        chk(status[3:0] == 8 && rec_count == 1, "R10 busy writes dropped, R9 refilled", status, 16'h1008);
        begin
            int len = 0;
            wait_busy(1);
            while (status[14]) begin len++; @(negedge clk); end
            chk(len == 11, "R9 busy length", len, 11);
        end
        for (int i = 0; i < 15; i++) begin wait_busy(1); wait_busy(0); end
        chk(rec_count == 15, "R9 saturation", rec_count, 15);
        repeat (20) @(posedge clk);
        tick_in(); ch_en = 0;
        repeat (4) @(posedge clk);
        @(negedge clk);
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule